// File: doc/BRIEF.md
# Code-Transition Level Search Controller

This block runs a statistical search for the stimulus level at which a converter under test starts to produce a chosen output code. It drives a stimulus DAC word and, at each level, collects a fixed number of valid converter samples. It counts how many of those samples are at or above the target code. The level is then moved toward the point where half of the samples reach the target. The level found at that point is reported as the transition level of the target code.

The search starts a little below the expected level and climbs in programmable steps. When the exceed ratio crosses one half, the step is halved and the direction turns. The search ends once a crossing is seen with a one-LSB step. A settle delay after every stimulus change discards the samples taken while the level is still moving. If the stimulus hits either end of its range before a crossing is found, the search stops and raises an error flag.

Top module: `tls_search_ctrl`

## Requirements
- R1: A `start` pulse while idle loads the stimulus with `init_level` minus 82, floored at 0. The value 82 is 2% of the 4096-step full scale. `busy` rises in the next cycle, and the sample counters and `not_found` are cleared.
- R2: `dac_code` does not change while a trial is collecting samples.
- R3: After every stimulus change, the first `settle_cycles`+1 cycles are a settle window. `smp_valid` and `smp_code` have no effect during that window.
- R4: `len_sel` sets the trial length in valid samples: 0 gives 64, 1 gives 256, 2 gives 1024 and 3 gives 4096. A sample counts as exceeding when `smp_code` >= `target_code`, compared unsigned.
- R5: The search begins moving upward with step `init_step`; a step of 0 is taken as 1. A trial in which the exceed count stays on the same side as before moves the level by the step. At full scale the level is clamped to 4095, and at the bottom it is clamped to 0. A trial that crosses the half mark (exceed count >= half while moving up, or below half while moving down) halves the step, reverses the direction and moves the level by the new step.
- R6: A crossing with step 1 ends the search. `t_level` becomes the level of the current trial when moving up, or that level plus 1 when moving down. `done` pulses for exactly one cycle, `busy` falls in that same cycle, and `t_level` holds its value afterwards.
- R7: If a trial asks for an upward move at level 4095, or a downward move at level 0, the search ends with `not_found` set and no `done` pulse. `not_found` is held until the next start.
- R8: `start` is ignored while a search is in progress.
- R9: After reset, `dac_code`, `busy`, `done`, `not_found` and `t_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when idle |
| target_code | input | CODE_W | Code whose transition level is sought |
| init_level | input | DAC_W | Expected transition level (stimulus units) |
| init_step | input | DAC_W | Initial stimulus step |
| len_sel | input | 2 | Trial length select |
| settle_cycles | input | SETTLE_W | Settle delay after each stimulus change |
| smp_valid | input | 1 | Converter sample qualifier |
| smp_code | input | CODE_W | Converter output sample |
| dac_code | output | DAC_W | Stimulus DAC word |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse with final result |
| not_found | output | 1 | Search hit a range end without crossing |
| t_level | output | DAC_W | Reported transition level |

## Verification
The assertions assume that `start` arrives only as a sampled level at a clock edge. They also assume that the configuration inputs need only be valid in the start cycle, because they are captured then. The bench drives every input on the falling edge, and it changes the configuration only together with a start pulse. The second start pulse, issued during a search, is there to exercise R8 rather than to reconfigure a running search. The converter samples are produced from the bench's own model of the stimulus level with bounded pseudo-random noise. Settle windows therefore see sample traffic, and the valid pattern can have gaps, yet each trial still finishes.

// File: rtl/tls_pkg.sv
package tls_pkg;

   localparam int MAX_TRIAL = 4096;
   localparam int CNT_W     = $clog2(MAX_TRIAL) + 1;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_ACQ    = 2'd2,
      ST_EVAL   = 2'd3
   } tls_state_t;

   // trial length: 64 << (2 * sel)
   function automatic logic [CNT_W-1:0] trial_len(input logic [1:0] sel);
      logic [CNT_W-1:0] base;
      base = CNT_W'(64);
      return base << {sel, 1'b0};
   endfunction

endpackage

// File: rtl/tls_level_stepper.sv
module tls_level_stepper #(
   parameter int DAC_W = 12,
   parameter int OFFS  = 82
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic             above,
   input  logic [DAC_W-1:0] init_level,
   input  logic [DAC_W-1:0] init_step,
   output logic [DAC_W-1:0] level_q,
   output logic             conv,
   output logic             bound,
   output logic [DAC_W-1:0] t_cand
);

   localparam logic [DAC_W-1:0] LVL_MAX = '1;
   localparam logic [DAC_W-1:0] OFFS_V  = DAC_W'(OFFS);

   logic [DAC_W-1:0] step_q;
   logic             up_q;
   logic             crossing;
   logic [DAC_W-1:0] start_lvl;

   function automatic logic [DAC_W-1:0] move(input logic [DAC_W-1:0] lvl,
                                            input logic [DAC_W-1:0] stp,
                                            input logic             up);
      logic [DAC_W:0] sum;
      sum = {1'b0, lvl} + {1'b0, stp};
      if (up)
         return sum[DAC_W] ? LVL_MAX : sum[DAC_W-1:0];
      else
         return (stp > lvl) ? '0 : lvl - stp;
   endfunction

   assign crossing  = up_q ? above : !above;
   assign conv      = crossing && (step_q == DAC_W'(1));
   assign bound     = !crossing && (up_q ? (level_q == LVL_MAX) : (level_q == '0));
   assign t_cand    = up_q ? level_q : level_q + DAC_W'(1);
   assign start_lvl = (init_level > OFFS_V) ? init_level - OFFS_V : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         step_q  <= DAC_W'(1);
         up_q    <= 1'b1;
      end else if (load) begin
         level_q <= start_lvl;
         step_q  <= (init_step == '0) ? DAC_W'(1) : init_step;
         up_q    <= 1'b1;
      end else if (adv && !conv && !bound) begin
         if (crossing) begin
            step_q  <= step_q >> 1;
            up_q    <= !up_q;
            level_q <= move(level_q, step_q >> 1, !up_q);
         end else begin
            level_q <= move(level_q, step_q, up_q);
         end
      end
   end

endmodule

// File: rtl/tls_trial_counter.sv
module tls_trial_counter
   import tls_pkg::*;
#(
   parameter int CODE_W   = 10,
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                in_settle,
   input  logic                in_acq,
   input  logic [SETTLE_W-1:0] settle_len,
   input  logic                smp_valid,
   input  logic [CODE_W-1:0]   smp_code,
   input  logic [CODE_W-1:0]   target,
   input  logic [CNT_W-1:0]    n_len,
   output logic                settle_over,
   output logic                trial_full,
   output logic                above,
   output logic [CNT_W-1:0]    taken_q
);

   logic [SETTLE_W-1:0] scnt_q;
   logic [CNT_W-1:0]    exc_q;
   logic                hit;

   assign hit         = smp_code >= target;
   assign settle_over = in_settle && (scnt_q == settle_len);
   assign trial_full  = in_acq && smp_valid && ((taken_q + CNT_W'(1)) == n_len);
   assign above       = exc_q >= (n_len >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt_q  <= '0;
         taken_q <= '0;
         exc_q   <= '0;
      end else if (clear) begin
         scnt_q  <= '0;
         taken_q <= '0;
         exc_q   <= '0;
      end else begin
         if (in_settle && !settle_over)
            scnt_q <= scnt_q + SETTLE_W'(1);
         if (in_acq && smp_valid) begin
            taken_q <= taken_q + CNT_W'(1);
            if (hit)
               exc_q <= exc_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/tls_search_ctrl.sv
module tls_search_ctrl
   import tls_pkg::*;
#(
   parameter int DAC_W    = 12,
   parameter int CODE_W   = 10,
   parameter int SETTLE_W = 8,
   parameter int OFFS_PCT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CODE_W-1:0]   target_code,
   input  logic [DAC_W-1:0]    init_level,
   input  logic [DAC_W-1:0]    init_step,
   input  logic [1:0]          len_sel,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                smp_valid,
   input  logic [CODE_W-1:0]   smp_code,
   output logic [DAC_W-1:0]    dac_code,
   output logic                busy,
   output logic                done,
   output logic                not_found,
   output logic [DAC_W-1:0]    t_level
);

   localparam int FULL_SCALE = 1 << DAC_W;
   localparam int OFFS       = (FULL_SCALE * OFFS_PCT + 50) / 100;

   generate
      if (DAC_W < 8 || DAC_W > 20) begin : g_bad_dac
         $error("tls_search_ctrl: DAC_W out of range");
      end
      if (CODE_W < 2 || CODE_W > DAC_W) begin : g_bad_code
         $error("tls_search_ctrl: CODE_W must be 2..DAC_W");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("tls_search_ctrl: SETTLE_W must be positive");
      end
      if (OFFS_PCT < 0 || OFFS_PCT > 50) begin : g_bad_offs
         $error("tls_search_ctrl: OFFS_PCT out of range");
      end
   endgenerate

   tls_state_t          state_q;
   logic [CODE_W-1:0]   tgt_q;
   logic [SETTLE_W-1:0] settle_q;
   logic [CNT_W-1:0]    len_q;
   logic                done_q;
   logic                err_q;
   logic [DAC_W-1:0]    t_q;

   logic                load;
   logic                clear;
   logic                adv;
   logic                conv;
   logic                bound;
   logic                above;
   logic                settle_over;
   logic                trial_full;
   logic [CNT_W-1:0]    taken_w;
   logic [DAC_W-1:0]    level_w;
   logic [DAC_W-1:0]    t_cand;

   assign load  = (state_q == ST_IDLE) && start;
   assign adv   = (state_q == ST_EVAL);
   assign clear = load || (adv && !conv && !bound);

   tls_level_stepper #(
      .DAC_W (DAC_W),
      .OFFS  (OFFS)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .adv        (adv),
      .above      (above),
      .init_level (init_level),
      .init_step  (init_step),
      .level_q    (level_w),
      .conv       (conv),
      .bound      (bound),
      .t_cand     (t_cand)
   );

   tls_trial_counter #(
      .CODE_W   (CODE_W),
      .SETTLE_W (SETTLE_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .in_settle   (state_q == ST_SETTLE),
      .in_acq      (state_q == ST_ACQ),
      .settle_len  (settle_q),
      .smp_valid   (smp_valid),
      .smp_code    (smp_code),
      .target      (tgt_q),
      .n_len       (len_q),
      .settle_over (settle_over),
      .trial_full  (trial_full),
      .above       (above),
      .taken_q     (taken_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tgt_q    <= '0;
         settle_q <= '0;
         len_q    <= trial_len(2'd0);
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         t_q      <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  tgt_q    <= target_code;
                  settle_q <= settle_cycles;
                  len_q    <= trial_len(len_sel);
                  err_q    <= 1'b0;
                  state_q  <= ST_SETTLE;
               end
            end
            ST_SETTLE: if (settle_over) state_q <= ST_ACQ;
            ST_ACQ:    if (trial_full)  state_q <= ST_EVAL;
            ST_EVAL: begin
               if (conv) begin
                  done_q  <= 1'b1;
                  t_q     <= t_cand;
                  state_q <= ST_IDLE;
               end else if (bound) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_SETTLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dac_code  = level_w;
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign not_found = err_q;
   assign t_level   = t_q;

endmodule

module tls_search_chk
   import tls_pkg::*;
#(
   parameter int DAC_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             not_found,
   input logic [DAC_W-1:0] dac_code,
   input tls_state_t       state_q,
   input logic [CNT_W-1:0] taken_w,
   input logic [CNT_W-1:0] len_q
);

   AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy) else $error("start did not raise busy"); // R1

   AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACQ) |=> $stable(dac_code)) else $error("stimulus moved in trial"); // R2

   AST_SETTLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |-> (taken_w == '0)) else $error("sample counted in settle"); // R3

   AST_TRIAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_w <= len_q)) else $error("trial overran its length"); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !not_found)) else $error("done with busy or error"); // R6

   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (not_found && !start) |=> not_found) else $error("error flag dropped"); // R7

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && state_q != ST_EVAL) |=> busy) else $error("start disturbed search"); // R8

endmodule

bind tls_search_ctrl tls_search_chk #(.DAC_W(DAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .not_found (not_found),
   .dac_code  (dac_code),
   .state_q   (state_q),
   .taken_w   (taken_w),
   .len_q     (len_q)
);

// File: tb/tls_search_ctrl_tb.sv
module tls_search_ctrl_tb_top;

   localparam int DAC_W    = 12;
   localparam int CODE_W   = 10;
   localparam int SETTLE_W = 8;
   localparam int LMAX     = (1 << DAC_W) - 1;
   localparam int WD_LIMIT = 190000;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                start = 1'b0;
   logic [CODE_W-1:0]   target_code = '0;
   logic [DAC_W-1:0]    init_level = '0;
   logic [DAC_W-1:0]    init_step = '0;
   logic [1:0]          len_sel = '0;
   logic [SETTLE_W-1:0] settle_cycles = '0;
   logic                smp_valid = 1'b0;
   logic [CODE_W-1:0]   smp_code = '0;
   logic [DAC_W-1:0]    dac_code;
   logic                busy;
   logic                done;
   logic                not_found;
   logic [DAC_W-1:0]    t_level;

   always #4 clk = ~clk;

   tls_search_ctrl #(
      .DAC_W(DAC_W), .CODE_W(CODE_W), .SETTLE_W(SETTLE_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .target_code(target_code),
      .init_level(init_level), .init_step(init_step), .len_sel(len_sel),
      .settle_cycles(settle_cycles), .smp_valid(smp_valid), .smp_code(smp_code),
      .dac_code(dac_code), .busy(busy), .done(done), .not_found(not_found),
      .t_level(t_level)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int done_seen = 0;
   int amode = 0;   // 0 noisy converter, 1 stuck at 0, 2 stuck at top
   int vmode = 0;   // 0 always valid, 1 gappy
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference
   int m_ph = 0, m_lvl = 0, m_step = 1, m_up = 1, m_scnt = 0;
   int m_taken = 0, m_exc = 0, m_len = 64, m_tgt = 0, m_set = 0;
   int m_done = 0, m_err = 0, m_t = 0;
   bit m_above, m_cross;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic int mv(input int l, input int s, input int up);
      int r;
      r = up ? l + s : l - s;
      if (r > LMAX) r = LMAX;
      if (r < 0) r = 0;
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_lvl = 0; m_step = 1; m_up = 1; m_done = 0; m_err = 0; m_t = 0;
         m_scnt = 0; m_taken = 0; m_exc = 0;
      end else begin
         m_done = 0;
         case (m_ph)
            0: if (start) begin
               m_lvl = (int'(init_level) > 82) ? int'(init_level) - 82 : 0;
               m_step = (init_step == 0) ? 1 : int'(init_step);
               m_up = 1; m_scnt = 0; m_taken = 0; m_exc = 0; m_err = 0;
               m_tgt = int'(target_code); m_set = int'(settle_cycles);
               m_len = 64 << (2 * int'(len_sel));
               m_ph = 1;
            end
            1: if (m_scnt == m_set) m_ph = 2; else m_scnt++;
            2: if (smp_valid) begin
               m_taken++;
               if (int'(smp_code) >= m_tgt) m_exc++;
               if (m_taken == m_len) m_ph = 3;
            end
            default: begin
               m_above = (2 * m_exc >= m_len);
               m_cross = m_up ? m_above : !m_above;
               if (m_cross && m_step == 1) begin
                  m_t = m_up ? m_lvl : m_lvl + 1;
                  m_done = 1; m_ph = 0;
               end else if (!m_cross && ((m_up && m_lvl == LMAX) || (!m_up && m_lvl == 0))) begin
                  m_err = 1; m_ph = 0;
               end else begin
                  if (m_cross) begin m_step = m_step / 2; m_up = !m_up; end
                  m_lvl = mv(m_lvl, m_step, m_up);
                  m_scnt = 0; m_taken = 0; m_exc = 0; m_ph = 1;
               end
            end
         endcase
      end
   end

   // per-cycle comparison and converter stimulus
   always @(negedge clk) begin
      int noise, v;
      cyc++;
      chk("R2/R3/R5 dac_code", int'(dac_code), m_lvl);
      chk("R1 busy", int'(busy), (m_ph != 0) ? 1 : 0);
      chk("R6 done", int'(done), m_done);
      chk("R7 not_found", int'(not_found), m_err);
      chk("R6 t_level", int'(t_level), m_t);
      if (done) done_seen++;
      lfsr = {lfsr[14:0], 1'b0} ^ (lfsr[15] ? 16'h1021 : 16'h0000);
      noise = int'(lfsr % 16'd9) - 4;
      v = m_lvl + noise;
      if (v < 0) v = 0;
      if (v > LMAX) v = LMAX;
      case (amode)
         1: smp_code = '0;
         2: smp_code = '1;
         default: smp_code = CODE_W'(v / 4);
      endcase
      smp_valid = (vmode == 0) ? 1'b1 : lfsr[3];
      if (cyc > WD_LIMIT) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         summary();
      end
   end

   task automatic launch(input int tgt, input int lvl, input int stp, input int sel,
                         input int st);
      @(negedge clk);
      target_code = CODE_W'(tgt); init_level = DAC_W'(lvl); init_step = DAC_W'(stp);
      len_sel = 2'(sel); settle_cycles = SETTLE_W'(st);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 start level", int'(dac_code), (lvl > 82) ? lvl - 82 : 0);
      chk("R1 busy after start", int'(busy), 1);
      chk("R7 error cleared by start", int'(not_found), 0);
   endtask

   task automatic finish_search(input int tgt, input int exp_err, input int ds0, input string rq);
      while (m_ph != 0) @(negedge clk);
      @(negedge clk);
      chk("R6 done pulse count", done_seen - ds0, exp_err ? 0 : 1);
      chk("R7 not_found result", int'(not_found), exp_err);
      if (!exp_err) begin
         int d;
         d = int'(t_level) - 4 * tgt;
         if (d < 0) d = -d;
         n_cmp++;
         if (d > 6) begin
            n_bad++;
            $display("FAIL %s t_level actual=%0d expected=%0d+-6", rq, t_level, 4 * tgt);
         end
      end
   endtask

   task automatic run(input int tgt, input int lvl, input int stp, input int sel, input int st,
                      input int vm, input int am, input int exp_err, input string rq);
      int ds0;
      vmode = vm; amode = am;
      ds0 = done_seen;
      launch(tgt, lvl, stp, sel, st);
      finish_search(tgt, exp_err, ds0, rq);
   endtask

   initial begin
      int ds0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 dac_code", int'(dac_code), 0);
      chk("R9 busy", int'(busy), 0);
      chk("R9 done", int'(done), 0);
      chk("R9 not_found", int'(not_found), 0);
      chk("R9 t_level", int'(t_level), 0);

      run(200, 800, 32, 0, 3, 0, 0, 0, "R4 len 64");
      run(500, 2000, 64, 1, 5, 1, 0, 0, "R4 len 256 gappy");
      run(100, 400, 16, 2, 20, 0, 0, 0, "R3 long settle len 1024");
      run(250, 1000, 0, 0, 0, 0, 0, 0, "R5 zero step");
      run(5, 3600, 200, 0, 2, 0, 1, 1, "R7 top end");
      run(5, 10, 8, 0, 2, 0, 2, 1, "R7 bottom end");
      run(900, 3600, 8, 3, 2, 0, 0, 0, "R4 len 4096");

      // R8: second start during a search has no effect
      vmode = 0; amode = 0;
      ds0 = done_seen;
      launch(300, 1200, 32, 0, 1);
      repeat (150) @(negedge clk);
      target_code = CODE_W'(50); init_level = DAC_W'(200);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy kept", int'(busy), 1);
      finish_search(300, 0, ds0, "R8 start while busy");

      summary();
   end

endmodule